// File: doc/BRIEF.md
# Descriptor Cookie Translation Unit

This block turns a 20-bit descriptor cookie into the 64-bit virtual address of the descriptor it names. It does this with a two-level table walk. The upper cookie field indexes a primary table held in on-chip memory. The entry it selects gives the physical base of a secondary page in external memory. The lower cookie field then picks an 8-byte slot in that page. The slot holds the descriptor address, and that address is returned.

Each request carries a pool selector (transmit or receive, chip number, pool number). The block turns this selector into the byte offset of that pool's primary table. Two page layouts are supported. In aligned mode every primary entry is 32 bits and holds a 4 KB page number. In unaligned mode every entry is 64 bits and holds the full page address.

All data paths use valid/ready handshakes, and only one walk is in flight at a time:

- A cookie is accepted only while `ck_ready` is high.
- A memory request, once raised, stays valid with a stable address until its ready is seen.
- A result stays valid and stable until `out_ready` is high.
- Memory responses are taken only while the matching response-ready is high.

Top module: `cookie_xlate_top`

## Requirements
- R1: A clock edge with `rst_n` low (synchronous, active low) returns the unit to idle. Afterwards `ck_ready` is 1 and `out_valid`, `tbl_req_valid` and `pg_req_valid` are 0.
- R2: The cookie fields are fixed. Bits 8:0 are the slot number inside the secondary page. Bits 19:9 are the primary index.
- R3: With `mode_aligned`=0, the primary entry is at byte offset pool_base + index×8. The page base is bits 47:0 of the 64-bit word read there.
- R4: With `mode_aligned`=1, the primary entry is at byte offset pool_base + index×4. The request address is that offset with bits 2:0 cleared. Offset bit 2 picks the half of the returned word: 1 takes bits 63:32 and 0 takes bits 31:0. The page base is that 32-bit value shifted left by 12.
- R5: The page read address is page_base + slot×8. `out_va` is the full 64-bit word returned by that read, with `out_err`=0.
- R6: Transmit pool p has pool_base = p×TX_POOL_BYTES. Receive pool p on chip c has pool_base = NUM_TX_POOLS×TX_POOL_BYTES + (c×MAX_RX_POOLS + p)×RX_POOL_BYTES.
- R7: If the cookie index is greater than or equal to `tbl_entries`, the result has `out_err`=1 and `out_va`=0, and no table or page request is issued. An index of `tbl_entries`−1 is translated normally.
- R8: Only one walk is in flight. `ck_ready` stays low from the accepting edge until the result has been taken.
- R9: A raised request keeps its valid and address until its ready is seen. A raised result keeps `out_valid`, `out_va` and `out_err` until `out_ready` is high.
- R10: `mode_aligned` is sampled when the cookie is accepted. Changing it during a walk does not affect that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_aligned | input | 1 | 1: 32-bit page-number entries; 0: 64-bit full-address entries |
| tbl_entries | input | 12 | Number of valid primary entries |
| ck_valid | input | 1 | Cookie request valid |
| ck_ready | output | 1 | Unit idle, cookie can be taken |
| ck_cookie | input | 20 | Cookie to translate |
| ck_is_rx | input | 1 | 1 selects a receive pool |
| ck_chip | input | 1 | Chip number (receive pools) |
| ck_pool | input | 2 | Pool number |
| tbl_req_valid | output | 1 | Primary table read request |
| tbl_req_ready | input | 1 | Table accepts request |
| tbl_req_addr | output | 16 | 8-byte-aligned on-chip byte address |
| tbl_rsp_valid | input | 1 | Table read data valid |
| tbl_rsp_ready | output | 1 | Unit waiting for table data |
| tbl_rsp_data | input | 64 | 8-byte table word |
| pg_req_valid | output | 1 | Page slot read request |
| pg_req_ready | input | 1 | Page memory accepts request |
| pg_req_addr | output | 48 | Physical slot byte address |
| pg_rsp_valid | input | 1 | Slot data valid |
| pg_rsp_ready | output | 1 | Unit waiting for slot data |
| pg_rsp_data | input | 64 | Slot contents |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken |
| out_va | output | 64 | Descriptor virtual address |
| out_err | output | 1 | Index out of range |

## Verification
The hardest case to reach from the ports is R10. A mode change only matters if it lands after the accepting edge but before the table data comes back. The driver therefore flips `mode_aligned` on the falling edge right after acceptance, while the table responder adds delay cycles. The R4 half-select case is hard in a different way: it is only seen if the cookies use odd primary indices and the table words carry different upper and lower halves. The memory models therefore encode the address differently in each half. The R7 range check is proven by counting memory handshakes around an out-of-range cookie, with indices equal to the limit and at the field maximum.

// File: rtl/cx_pkg.sv
package cx_pkg;
  localparam int COOKIE_W   = 20;
  localparam int SLOT_W     = 9;
  localparam int IDX_W      = COOKIE_W - SLOT_W;
  localparam int SLOT_SHIFT = 3;
  localparam int PAGE_SHIFT = 12;
  localparam int WORD_W     = 64;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRI_REQ,
    ST_PRI_WAIT,
    ST_SEC_REQ,
    ST_SEC_WAIT,
    ST_RESP
  } walk_st_e;
endpackage

// File: rtl/cx_pool_base.sv
module cx_pool_base #(
  parameter int CMEM_AW       = 16,
  parameter int NUM_TX_POOLS  = 4,
  parameter int MAX_RX_POOLS  = 4,
  parameter int NUM_CHIPS     = 2,
  parameter int TX_POOL_BYTES = 256,
  parameter int RX_POOL_BYTES = 256,
  localparam int CHIP_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1,
  localparam int POOL_W = $clog2((NUM_TX_POOLS > MAX_RX_POOLS) ? NUM_TX_POOLS : MAX_RX_POOLS)
) (
  input  logic               is_rx,
  input  logic [CHIP_W-1:0]  chip,
  input  logic [POOL_W-1:0]  pool,
  output logic [CMEM_AW-1:0] base
);
  localparam int RX_START = NUM_TX_POOLS * TX_POOL_BYTES;

  logic [31:0] rx_slot;

  generate
    if (NUM_CHIPS > 1) begin : g_multi_chip
      assign rx_slot = 32'(chip) * 32'(MAX_RX_POOLS) + 32'(pool);
    end else begin : g_single_chip
      assign rx_slot = 32'(pool);
    end
  endgenerate

  always_comb begin
    if (is_rx)
      base = CMEM_AW'(32'(RX_START) + rx_slot * 32'(RX_POOL_BYTES));
    else
      base = CMEM_AW'(32'(pool) * 32'(TX_POOL_BYTES));
  end
endmodule

// File: rtl/cx_addr_gen.sv
module cx_addr_gen import cx_pkg::*; #(
  parameter int CMEM_AW = 16,
  parameter int PA_W    = 48
) (
  input  logic               aligned,
  input  logic [CMEM_AW-1:0] pool_base,
  input  logic [IDX_W-1:0]   idx,
  input  logic [SLOT_W-1:0]  slot,
  input  logic [WORD_W-1:0]  tbl_word,
  input  logic [PA_W-1:0]    page_base,
  output logic [CMEM_AW-1:0] tbl_addr,
  output logic [PA_W-1:0]    page_from_word,
  output logic [PA_W-1:0]    slot_addr
);
  logic [CMEM_AW-1:0] entry_off;
  logic [CMEM_AW-1:0] entry_byte;
  logic               upper_half;
  logic [31:0]        half_word;

  always_comb begin
    if (aligned) entry_off = CMEM_AW'({idx, 2'b00});
    else         entry_off = CMEM_AW'({idx, 3'b000});
    entry_byte = pool_base + entry_off;
    tbl_addr   = {entry_byte[CMEM_AW-1:3], 3'b000};
  end

  // In aligned mode two 32-bit entries share one 8-byte word.
  assign upper_half = aligned & entry_byte[2];
  assign half_word  = upper_half ? tbl_word[63:32] : tbl_word[31:0];

  always_comb begin
    if (aligned) page_from_word = PA_W'({half_word, {PAGE_SHIFT{1'b0}}});
    else         page_from_word = tbl_word[PA_W-1:0];
  end

  assign slot_addr = page_base + PA_W'({slot, {SLOT_SHIFT{1'b0}}});
endmodule

// File: rtl/cx_walk_fsm.sv
module cx_walk_fsm import cx_pkg::*; (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ck_fire,
  input  logic     range_err,
  input  logic     tbl_req_ready,
  input  logic     tbl_rsp_valid,
  input  logic     pg_req_ready,
  input  logic     pg_rsp_valid,
  input  logic     out_ready,
  output walk_st_e state
);
  walk_st_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (ck_fire) nxt = range_err ? ST_RESP : ST_PRI_REQ;
      ST_PRI_REQ:  if (tbl_req_ready) nxt = ST_PRI_WAIT;
      ST_PRI_WAIT: if (tbl_rsp_valid) nxt = ST_SEC_REQ;
      ST_SEC_REQ:  if (pg_req_ready)  nxt = ST_SEC_WAIT;
      ST_SEC_WAIT: if (pg_rsp_valid)  nxt = ST_RESP;
      ST_RESP:     if (out_ready)     nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // R9: a pending result is not dropped without out_ready
  p_resp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESP && !out_ready) |=> state == ST_RESP);

  // R8: a walk never restarts from a non-idle state
  p_no_reentry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && state != ST_RESP) |=> state != ST_IDLE);
endmodule

// File: rtl/cookie_xlate_top.sv
module cookie_xlate_top import cx_pkg::*; #(
  parameter int CMEM_AW       = 16,
  parameter int PA_W          = 48,
  parameter int NUM_TX_POOLS  = 4,
  parameter int MAX_RX_POOLS  = 4,
  parameter int NUM_CHIPS     = 2,
  parameter int TX_POOL_BYTES = 256,
  parameter int RX_POOL_BYTES = 256,
  localparam int CHIP_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1,
  localparam int POOL_W = $clog2((NUM_TX_POOLS > MAX_RX_POOLS) ? NUM_TX_POOLS : MAX_RX_POOLS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_aligned,
  input  logic [IDX_W:0]     tbl_entries,
  input  logic               ck_valid,
  output logic               ck_ready,
  input  logic [COOKIE_W-1:0] ck_cookie,
  input  logic               ck_is_rx,
  input  logic [CHIP_W-1:0]  ck_chip,
  input  logic [POOL_W-1:0]  ck_pool,
  output logic               tbl_req_valid,
  input  logic               tbl_req_ready,
  output logic [CMEM_AW-1:0] tbl_req_addr,
  input  logic               tbl_rsp_valid,
  output logic               tbl_rsp_ready,
  input  logic [WORD_W-1:0]  tbl_rsp_data,
  output logic               pg_req_valid,
  input  logic               pg_req_ready,
  output logic [PA_W-1:0]    pg_req_addr,
  input  logic               pg_rsp_valid,
  output logic               pg_rsp_ready,
  input  logic [WORD_W-1:0]  pg_rsp_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_va,
  output logic               out_err
);
  walk_st_e            state;
  logic                ck_fire;
  logic                range_err;
  logic [COOKIE_W-1:0] cookie_q;
  logic                rx_q;
  logic [CHIP_W-1:0]   chip_q;
  logic [POOL_W-1:0]   pool_q;
  logic                aligned_q;
  logic [PA_W-1:0]     page_base_q;
  logic [WORD_W-1:0]   va_q;
  logic                err_q;
  logic [CMEM_AW-1:0]  pool_base;
  logic [PA_W-1:0]     page_from_word;
  logic [PA_W-1:0]     slot_addr;

  assign ck_fire   = ck_valid && ck_ready;
  assign range_err = {1'b0, ck_cookie[COOKIE_W-1:SLOT_W]} >= tbl_entries;

  cx_walk_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .ck_fire       (ck_fire),
    .range_err     (range_err),
    .tbl_req_ready (tbl_req_ready),
    .tbl_rsp_valid (tbl_rsp_valid),
    .pg_req_ready  (pg_req_ready),
    .pg_rsp_valid  (pg_rsp_valid),
    .out_ready     (out_ready),
    .state         (state)
  );

  cx_pool_base #(
    .CMEM_AW(CMEM_AW), .NUM_TX_POOLS(NUM_TX_POOLS), .MAX_RX_POOLS(MAX_RX_POOLS),
    .NUM_CHIPS(NUM_CHIPS), .TX_POOL_BYTES(TX_POOL_BYTES), .RX_POOL_BYTES(RX_POOL_BYTES)
  ) u_base (
    .is_rx (rx_q),
    .chip  (chip_q),
    .pool  (pool_q),
    .base  (pool_base)
  );

  cx_addr_gen #(.CMEM_AW(CMEM_AW), .PA_W(PA_W)) u_addr (
    .aligned        (aligned_q),
    .pool_base      (pool_base),
    .idx            (cookie_q[COOKIE_W-1:SLOT_W]),
    .slot           (cookie_q[SLOT_W-1:0]),
    .tbl_word       (tbl_rsp_data),
    .page_base      (page_base_q),
    .tbl_addr       (tbl_req_addr),
    .page_from_word (page_from_word),
    .slot_addr      (slot_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cookie_q    <= '0;
      rx_q        <= 1'b0;
      chip_q      <= '0;
      pool_q      <= '0;
      aligned_q   <= 1'b0;
      page_base_q <= '0;
      va_q        <= '0;
      err_q       <= 1'b0;
    end else begin
      if (ck_fire) begin
        cookie_q  <= ck_cookie;
        rx_q      <= ck_is_rx;
        chip_q    <= ck_chip;
        pool_q    <= ck_pool;
        aligned_q <= mode_aligned;
        err_q     <= range_err;
        va_q      <= '0;
      end
      if (tbl_rsp_valid && tbl_rsp_ready) page_base_q <= page_from_word;
      if (pg_rsp_valid && pg_rsp_ready)   va_q        <= pg_rsp_data;
    end
  end

  assign ck_ready      = (state == ST_IDLE);
  assign tbl_req_valid = (state == ST_PRI_REQ);
  assign tbl_rsp_ready = (state == ST_PRI_WAIT);
  assign pg_req_valid  = (state == ST_SEC_REQ);
  assign pg_rsp_ready  = (state == ST_SEC_WAIT);
  assign pg_req_addr   = slot_addr;
  assign out_valid     = (state == ST_RESP);
  assign out_va        = va_q;
  assign out_err       = err_q;

  // R8: while a cookie can be taken, nothing else is in flight
  p_single_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ck_ready |-> !tbl_req_valid && !pg_req_valid && !out_valid);

  // R7: out-of-range index goes straight to an error result
  p_range_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_fire && range_err) |=> out_valid && out_err && out_va == '0);

  // R7: in-range index starts with a table read
  p_range_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_fire && !range_err) |=> tbl_req_valid);

  // R9: request hold rules
  p_tbl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_req_valid && !tbl_req_ready) |=> tbl_req_valid && $stable(tbl_req_addr));
  p_pg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_req_valid && !pg_req_ready) |=> pg_req_valid && $stable(pg_req_addr));

  // R9: result hold rule
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_va) && $stable(out_err));

  // R4: table requests are always 8-byte aligned
  p_tbl_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_req_valid |-> tbl_req_addr[2:0] == 3'b000);
endmodule

// File: tb/sim_cookie_xlate_top.sv
module sim_cookie_xlate_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_aligned;
  logic [11:0] tbl_entries;
  logic        ck_valid;
  logic        ck_ready;
  logic [19:0] ck_cookie;
  logic        ck_is_rx;
  logic        ck_chip;
  logic [1:0]  ck_pool;
  logic        tbl_req_valid, tbl_req_ready, tbl_rsp_valid, tbl_rsp_ready;
  logic [15:0] tbl_req_addr;
  logic [63:0] tbl_rsp_data;
  logic        pg_req_valid, pg_req_ready, pg_rsp_valid, pg_rsp_ready;
  logic [47:0] pg_req_addr;
  logic [63:0] pg_rsp_data;
  logic        out_valid, out_ready, out_err;
  logic [63:0] out_va;

  int checks = 0;
  int failures = 0;
  int tbl_reqs = 0;
  int pg_reqs = 0;
  bit done = 0;

  logic [64:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cookie_xlate_top u0 (
    .clk(clk), .rst_n(rst_n), .mode_aligned(mode_aligned), .tbl_entries(tbl_entries),
    .ck_valid(ck_valid), .ck_ready(ck_ready), .ck_cookie(ck_cookie),
    .ck_is_rx(ck_is_rx), .ck_chip(ck_chip), .ck_pool(ck_pool),
    .tbl_req_valid(tbl_req_valid), .tbl_req_ready(tbl_req_ready), .tbl_req_addr(tbl_req_addr),
    .tbl_rsp_valid(tbl_rsp_valid), .tbl_rsp_ready(tbl_rsp_ready), .tbl_rsp_data(tbl_rsp_data),
    .pg_req_valid(pg_req_valid), .pg_req_ready(pg_req_ready), .pg_req_addr(pg_req_addr),
    .pg_rsp_valid(pg_rsp_valid), .pg_rsp_ready(pg_rsp_ready), .pg_rsp_data(pg_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_va(out_va), .out_err(out_err)
  );

  // Memory contents: the upper and lower halves differ so a wrong half shows up
  function automatic logic [63:0] cmem_word(input logic [15:0] a);
    return {16'h0003, a, 16'h0001, a};
  endfunction

  function automatic logic [63:0] page_word(input logic [47:0] a);
    return {a ^ 48'h5A5A_0F0F_3C3C, 16'hC0DE};
  endfunction

  // Expected translation built from R2..R6
  function automatic logic [63:0] model(input logic [19:0] ck, input logic rx,
                                        input logic chip, input logic [1:0] pool,
                                        input logic al);
    int unsigned base;
    logic [15:0] ba;
    logic [63:0] w;
    logic [47:0] pb;
    logic [31:0] half;
    base = rx ? (4*256 + (int'(chip)*4 + int'(pool))*256) : int'(pool)*256;
    if (al) ba = 16'(base + int'(ck[19:9])*4);
    else    ba = 16'(base + int'(ck[19:9])*8);
    w = cmem_word({ba[15:3], 3'b000});
    if (al) begin
      half = ba[2] ? w[63:32] : w[31:0];
      pb = {4'h0, half, 12'h000};
    end else begin
      pb = w[47:0];
    end
    return page_word(pb + 48'(ck[8:0]) * 48'd8);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Table memory responder
  initial begin : tbl_resp
    int dly = 0;
    logic [15:0] a;
    tbl_req_ready = 0; tbl_rsp_valid = 0; tbl_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (tbl_req_valid) begin
        repeat (dly) @(negedge clk);
        a = tbl_req_addr;
        tbl_req_ready = 1;
        @(negedge clk);
        tbl_req_ready = 0;
        tbl_reqs++;
        repeat (dly + 1) @(negedge clk);
        tbl_rsp_valid = 1;
        tbl_rsp_data = cmem_word(a);
        @(negedge clk);
        tbl_rsp_valid = 0;
        dly = (dly + 1) % 3;
      end
    end
  end

  // Page memory responder
  initial begin : pg_resp
    int dly = 1;
    logic [47:0] a;
    pg_req_ready = 0; pg_rsp_valid = 0; pg_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (pg_req_valid) begin
        repeat (dly) @(negedge clk);
        a = pg_req_addr;
        pg_req_ready = 1;
        @(negedge clk);
        pg_req_ready = 0;
        pg_reqs++;
        repeat (dly) @(negedge clk);
        pg_rsp_valid = 1;
        pg_rsp_data = page_word(a);
        @(negedge clk);
        pg_rsp_valid = 0;
        dly = (dly + 1) % 3;
      end
    end
  end

  // Monitor: pops expected items as results are taken
  initial begin : monitor
    int n = 0;
    bit stalled = 0;
    logic [64:0] held = '0;
    logic [64:0] e;
    string t;
    out_ready = 0;
    forever begin
      @(negedge clk);
      if (stalled) begin
        check("R9 hold", {63'd0, out_valid}, 64'd1);
        check("R9 hold", {out_err, out_va}, held);
      end
      out_ready = (n % 4) != 1;
      n++;
      stalled = out_valid && !out_ready;
      held = {out_err, out_va};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R5 unexpected result", 64'd1, 64'd0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, out_va, e[63:0]);
          check({t, " err"}, {63'd0, out_err}, {63'd0, e[64]});
        end
      end
    end
  end

  task automatic send(input string tag, input logic [19:0] ck, input logic rx,
                      input logic chip, input logic [1:0] pool, input logic al,
                      input bit flip_mode);
    logic err;
    err = {1'b0, ck[19:9]} >= tbl_entries;
    exp_q.push_back({err, err ? 64'd0 : model(ck, rx, chip, pool, al)});
    tag_q.push_back(tag);
    @(negedge clk);
    ck_cookie = ck; ck_is_rx = rx; ck_chip = chip; ck_pool = pool;
    mode_aligned = al; ck_valid = 1;
    while (!ck_ready) @(negedge clk);
    @(negedge clk);
    ck_valid = 0;
    if (flip_mode) mode_aligned = ~al;   // R10: change after acceptance
    check("R8 busy", {63'd0, ck_ready}, 64'd0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    int n0;
    rst_n = 0; mode_aligned = 0; tbl_entries = 12'd1000;
    ck_valid = 0; ck_cookie = '0; ck_is_rx = 0; ck_chip = 0; ck_pool = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 ck_ready", {63'd0, ck_ready}, 64'd1);
    check("R1 idle outputs", {61'd0, out_valid, tbl_req_valid, pg_req_valid}, 64'd0);
    rst_n = 1;

    // R3 / R2: unaligned entries
    send("R3 unaligned tx0", {11'd5, 9'd7}, 0, 0, 2'd0, 0, 0);
    send("R2 slot max", {11'd9, 9'd511}, 0, 0, 2'd1, 0, 0);
    // R4: aligned, even and odd index (lower / upper half)
    send("R4 aligned even", {11'd4, 9'd3}, 0, 0, 2'd1, 1, 0);
    send("R4 aligned odd", {11'd7, 9'd3}, 0, 0, 2'd1, 1, 0);
    // R6: pool bases
    send("R6 tx pool3", {11'd2, 9'd0}, 0, 0, 2'd3, 0, 0);
    send("R6 rx chip1 pool2", {11'd1, 9'd20}, 1, 1, 2'd2, 1, 0);
    send("R6 rx chip0 pool0", {11'd3, 9'd100}, 1, 0, 2'd0, 0, 0);
    // R5 / R7: boundary index just inside the limit
    send("R5 last valid index", {11'd999, 9'd1}, 0, 0, 2'd0, 1, 0);
    drain();

    // R7: out-of-range indices issue no memory traffic
    n0 = tbl_reqs + pg_reqs;
    send("R7 index at limit", {11'd1000, 9'd4}, 0, 0, 2'd0, 0, 0);
    send("R7 index max", {11'd2047, 9'd511}, 1, 1, 2'd3, 1, 0);
    drain();
    check("R7 no memory requests", 64'(tbl_reqs + pg_reqs), 64'(n0));

    // R10: mode flipped during the walk
    send("R10 aligned kept", {11'd11, 9'd9}, 0, 0, 2'd2, 1, 1);
    send("R10 unaligned kept", {11'd13, 9'd9}, 0, 0, 2'd2, 0, 1);
    // mixed back-to-back traffic
    for (int i = 0; i < 6; i++)
      send("R5 mixed", {11'(i * 37 + 1), 9'(i * 85)}, 1'(i), 1'(i >> 1), 2'(i), 1'(i >> 1), 0);
    drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule